// File: doc/BRIEF.md
# SPI Interrupt Flag Register

This block keeps the byte-wide interrupt flag register of an SPI peripheral that works either as bus host or as bus client. The surrounding datapath (shift register, baud generator, receive and transmit buffers) feeds it error pulses, the raw slave-select pin, a shift-finished pulse, an address-match pulse and three occupancy levels. A simple register bus gives it write and read strobes, a byte address and write data. It returns the flag byte and one interrupt request line. The request is the registered OR of every flag gated by its enable bit.

The flags do not share one rule. The error, select-low and transfer-done flags are sticky. Software clears them by writing a one to their bit. The transfer-done flag is also cleared by a write to the data register. The receive-complete and data-empty flags follow datapath levels, and an access to the data register drops them for one cycle. If a hardware set and a software clear fall in the same cycle, the set wins.

In client mode a small state machine tracks each transaction through three states. TXN_IDLE moves to TXN_AWAIT_ADDR on a select fall when address framing is on (transition *select*). It moves to TXN_ACCEPTED on a select fall when address framing is off (transition *select_plain*). TXN_AWAIT_ADDR moves to TXN_ACCEPTED on an address match (transition *match*). Both busy states return to TXN_IDLE on a select rise (transition *deselect*). Host mode forces TXN_IDLE (transition *host_force*).

Top module: `spi_irq_flags`

## Requirements
- R1: After reset the flag byte and the interrupt line are 0. Bits 6 to 4 of the flag byte always read 0. The flag layout is: bit 7 error, bit 3 select-low, bit 2 receive-complete, bit 1 transfer-done, bit 0 data-empty. The flag register is at bus address 0x18 and the data register at 0x28.
- R2: Bit 7 is set in the cycle after an underrun, overflow or length error pulse. It stays set until a bus write to 0x18 with bit 7 of the data at 1. Writing 0 there leaves it unchanged.
- R3: The slave-select pin passes through a two-flop synchronizer and an edge detector. Bit 3 is set after the third rising clock edge that follows a falling pin, but only in client mode (is_host=0) with select-low detection enabled. In all other cases a falling pin does not set it.
- R4: Bit 3 is cleared by a write to 0x18 with data bit 3 at 1.
- R5: Bit 2 equals rx_enable AND rx_unread, registered, except that it is 0 in the cycle after a bus read of 0x28. Writes to bit 2 of 0x18 have no effect.
- R6: In host mode, bit 1 is set after a shift_done pulse that arrives while tx_pending is 0. A pulse that arrives while tx_pending is 1 does not set it.
- R7: In client mode, bit 1 is set after the third rising edge that follows the select pin going high, which ends a transaction. When frame_fmt equals 2, it is set only if addr_match pulsed between the synchronized select fall and rise.
- R8: Bit 1 is cleared by a write to 0x18 with data bit 1 at 1, or by any bus write to 0x28.
- R9: Bit 0 equals tx_empty, registered, except that it is 0 in the cycle after a bus write to 0x28. Writes to bit 0 of 0x18 have no effect.
- R10: A hardware set and a software clear of the same sticky flag in the same cycle leave the flag set.
- R11: The interrupt line equals the OR over all bits of (flag AND irq_en), taken from the flag value of the previous cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| is_host | input | 1 | 1 = host mode, 0 = client mode |
| ssl_det_en | input | 1 | Enables select-low detection |
| frame_fmt | input | 4 | Frame format code; 2 selects address framing |
| rx_enable | input | 1 | Receiver enabled |
| err_underrun | input | 1 | Transmit underrun pulse |
| err_overflow | input | 1 | Buffer overflow pulse |
| err_length | input | 1 | Length error pulse |
| ss_pin | input | 1 | Raw asynchronous slave-select pin |
| addr_match | input | 1 | Client address matched pulse |
| shift_done | input | 1 | Host shift finished pulse |
| tx_pending | input | 1 | New transmit data waiting |
| rx_unread | input | 1 | Receive buffer holds unread data |
| tx_empty | input | 1 | Data register can take new data |
| bus_wr | input | 1 | Register write strobe |
| bus_rd | input | 1 | Register read strobe |
| bus_addr | input | 8 | Register byte address |
| bus_wdata | input | 8 | Register write data |
| irq_en | input | 8 | Per-flag interrupt enables |
| flags | output | 8 | Flag register value |
| irq | output | 1 | Interrupt request |

## Verification
The embedded properties assume that the error, shift_done and addr_match inputs are one-cycle pulses. They also assume that mode and frame format change only while no client transaction is in progress. The bench sets is_host and frame_fmt only while the select pin has been high for several cycles, and it drives every pulse for exactly one cycle. The select pin is held at each level for at least four cycles, so every edge passes through the synchronizer before the next edge arrives.

// File: rtl/spi_irq_pkg.sv
package spi_irq_pkg;
    localparam int FLAG_W  = 8;
    localparam int ERR_BIT = 7;
    localparam int SSL_BIT = 3;
    localparam int RXC_BIT = 2;
    localparam int TXC_BIT = 1;
    localparam int DRE_BIT = 0;
    localparam logic [3:0] FMT_ADDR = 4'h2;

    typedef enum logic [1:0] {
        TXN_IDLE,
        TXN_AWAIT_ADDR,
        TXN_ACCEPTED
    } txn_state_t;

    typedef enum logic [1:0] {
        KIND_NONE,
        KIND_STICKY,
        KIND_LEVEL
    } flag_kind_e;

    function automatic flag_kind_e kind_of(input int idx);
        if (idx == ERR_BIT || idx == SSL_BIT || idx == TXC_BIT) return KIND_STICKY;
        if (idx == RXC_BIT || idx == DRE_BIT) return KIND_LEVEL;
        return KIND_NONE;
    endfunction
endpackage

// File: rtl/spi_ss_sync.sv
module spi_ss_sync #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic pin,
    output logic fall,
    output logic rise
);
    logic [STAGES-1:0] chain;
    logic              prev;

    always_ff @(posedge clk) begin
        if (!rst_n) chain[0] <= 1'b1;
        else        chain[0] <= pin;
    end

    for (genvar i = 1; i < STAGES; i++) begin : g_stage
        always_ff @(posedge clk) begin
            if (!rst_n) chain[i] <= 1'b1;
            else        chain[i] <= chain[i-1];
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) prev <= 1'b1;
        else        prev <= chain[STAGES-1];
    end

    assign fall = prev & ~chain[STAGES-1];
    assign rise = ~prev & chain[STAGES-1];

    // R3
    single_fall_chk: assert property (@(posedge clk) disable iff (!rst_n)
        fall |=> !fall);
endmodule

// File: rtl/spi_client_txn.sv
module spi_client_txn
    import spi_irq_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic is_host,
    input  logic addr_mode,
    input  logic ss_fall,
    input  logic ss_rise,
    input  logic addr_match,
    output logic txn_done
);
    txn_state_t state, state_nx;

    always_ff @(posedge clk) begin
        if (!rst_n) state <= TXN_IDLE;
        else        state <= state_nx;
    end

    always_comb begin
        state_nx = state;
        if (is_host) begin
            state_nx = TXN_IDLE;
        end else begin
            unique case (state)
                TXN_IDLE: begin
                    if (ss_fall) state_nx = addr_mode ? TXN_AWAIT_ADDR : TXN_ACCEPTED;
                end
                TXN_AWAIT_ADDR: begin
                    if (ss_rise)         state_nx = TXN_IDLE;
                    else if (addr_match) state_nx = TXN_ACCEPTED;
                end
                TXN_ACCEPTED: begin
                    if (ss_rise) state_nx = TXN_IDLE;
                end
                default: state_nx = TXN_IDLE;
            endcase
        end
    end

    always_comb begin
        txn_done = !is_host && ss_rise && (state == TXN_ACCEPTED);
    end

    // R7
    host_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
        is_host |=> state == TXN_IDLE);
    // R7
    done_returns_chk: assert property (@(posedge clk) disable iff (!rst_n)
        txn_done |=> state == TXN_IDLE);
endmodule

// File: rtl/spi_flag_bank.sv
module spi_flag_bank
    import spi_irq_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic [FLAG_W-1:0] set_v,
    input  logic [FLAG_W-1:0] clr_v,
    input  logic [FLAG_W-1:0] lvl_v,
    output logic [FLAG_W-1:0] q
);
    for (genvar i = 0; i < FLAG_W; i++) begin : g_bit
        if (kind_of(i) == KIND_STICKY) begin : g_sticky
            always_ff @(posedge clk) begin
                if (!rst_n)        q[i] <= 1'b0;
                else if (set_v[i]) q[i] <= 1'b1;
                else if (clr_v[i]) q[i] <= 1'b0;
            end
            // R10
            set_wins_chk: assert property (@(posedge clk) disable iff (!rst_n)
                set_v[i] |=> q[i]);
        end else if (kind_of(i) == KIND_LEVEL) begin : g_level
            always_ff @(posedge clk) begin
                if (!rst_n) q[i] <= 1'b0;
                else        q[i] <= lvl_v[i];
            end
            // R5
            level_low_chk: assert property (@(posedge clk) disable iff (!rst_n)
                !lvl_v[i] |=> !q[i]);
        end else begin : g_none
            assign q[i] = 1'b0;
        end
    end
endmodule

// File: rtl/spi_irq_flags.sv
module spi_irq_flags
    import spi_irq_pkg::*;
#(
    parameter int               ADDR_W   = 8,
    parameter logic [ADDR_W-1:0] FLAG_OFS = 'h18,
    parameter logic [ADDR_W-1:0] DATA_OFS = 'h28,
    parameter int               SYNC_STG = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              is_host,
    input  logic              ssl_det_en,
    input  logic [3:0]        frame_fmt,
    input  logic              rx_enable,
    input  logic              err_underrun,
    input  logic              err_overflow,
    input  logic              err_length,
    input  logic              ss_pin,
    input  logic              addr_match,
    input  logic              shift_done,
    input  logic              tx_pending,
    input  logic              rx_unread,
    input  logic              tx_empty,
    input  logic              bus_wr,
    input  logic              bus_rd,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic [7:0]        bus_wdata,
    input  logic [7:0]        irq_en,
    output logic [7:0]        flags,
    output logic              irq
);
    logic              ss_fall, ss_rise, txn_done;
    logic              wr_flag, wr_data, rd_data, err_any;
    logic [FLAG_W-1:0] set_v, clr_v, lvl_v, q;

    assign wr_flag = bus_wr && (bus_addr == FLAG_OFS);
    assign wr_data = bus_wr && (bus_addr == DATA_OFS);
    assign rd_data = bus_rd && (bus_addr == DATA_OFS);
    assign err_any = err_underrun | err_overflow | err_length;

    spi_ss_sync #(.STAGES(SYNC_STG)) u_sync (
        .clk(clk), .rst_n(rst_n), .pin(ss_pin), .fall(ss_fall), .rise(ss_rise)
    );

    spi_client_txn u_txn (
        .clk(clk), .rst_n(rst_n), .is_host(is_host),
        .addr_mode(frame_fmt == FMT_ADDR),
        .ss_fall(ss_fall), .ss_rise(ss_rise), .addr_match(addr_match),
        .txn_done(txn_done)
    );

    always_comb begin
        set_v = '0;
        clr_v = '0;
        lvl_v = '0;
        set_v[ERR_BIT] = err_any;
        set_v[SSL_BIT] = !is_host && ssl_det_en && ss_fall;
        set_v[TXC_BIT] = is_host ? (shift_done && !tx_pending) : txn_done;
        clr_v[ERR_BIT] = wr_flag && bus_wdata[ERR_BIT];
        clr_v[SSL_BIT] = wr_flag && bus_wdata[SSL_BIT];
        clr_v[TXC_BIT] = (wr_flag && bus_wdata[TXC_BIT]) || wr_data;
        lvl_v[RXC_BIT] = rx_enable && rx_unread && !rd_data;
        lvl_v[DRE_BIT] = tx_empty && !wr_data;
    end

    spi_flag_bank u_bank (
        .clk(clk), .rst_n(rst_n), .set_v(set_v), .clr_v(clr_v), .lvl_v(lvl_v), .q(q)
    );

    always_ff @(posedge clk) begin
        if (!rst_n) irq <= 1'b0;
        else        irq <= |(q & irq_en);
    end

    assign flags = q;

    // R2
    err_set_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (err_underrun || err_overflow || err_length) |=> flags[ERR_BIT]);
    // R2
    err_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (flags[ERR_BIT] && !(bus_wr && bus_addr == FLAG_OFS && bus_wdata[ERR_BIT]))
        |=> flags[ERR_BIT]);
    // R9
    dre_write_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_wr && bus_addr == DATA_OFS) |=> !flags[DRE_BIT]);
    // R11
    irq_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ((flags & irq_en) == 8'h00) |=> !irq);
    // R1
    unused_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $past(bus_wr) |-> flags[6:4] == 3'b000);
endmodule

// File: tb/sim_spi_irq_flags.sv
module sim_spi_irq_flags;
    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic is_host = 1'b1, ssl_det_en = 1'b0, rx_enable = 1'b0;
    logic [3:0] frame_fmt = 4'h0;
    logic err_underrun = 0, err_overflow = 0, err_length = 0;
    logic ss_pin = 1'b1, addr_match = 0, shift_done = 0, tx_pending = 0;
    logic rx_unread = 0, tx_empty = 0, bus_wr = 0, bus_rd = 0;
    logic [7:0] bus_addr = 8'h00, bus_wdata = 8'h00, irq_en = 8'h00;
    logic [7:0] flags;
    logic irq;

    int checks = 0;
    int errors = 0;

    always #10 clk = ~clk;

    spi_irq_flags u0 (
        .clk(clk), .rst_n(rst_n), .is_host(is_host), .ssl_det_en(ssl_det_en),
        .frame_fmt(frame_fmt), .rx_enable(rx_enable), .err_underrun(err_underrun),
        .err_overflow(err_overflow), .err_length(err_length), .ss_pin(ss_pin),
        .addr_match(addr_match), .shift_done(shift_done), .tx_pending(tx_pending),
        .rx_unread(rx_unread), .tx_empty(tx_empty), .bus_wr(bus_wr), .bus_rd(bus_rd),
        .bus_addr(bus_addr), .bus_wdata(bus_wdata), .irq_en(irq_en),
        .flags(flags), .irq(irq)
    );

    // reference model state
    logic m_s1 = 1, m_s2 = 1, m_pv = 1;
    int   m_st = 0; // 0 idle, 1 awaiting address, 2 accepted
    logic [7:0] m_f = 8'h00;
    logic m_irq = 1'b0;

    logic [8:0] exq[$];
    string      tgq[$];

    always @(negedge clk) begin
        if (exq.size() > 0) begin
            logic [8:0] e;
            string t;
            e = exq.pop_front();
            t = tgq.pop_front();
            checks++;
            if ({irq, flags} !== e) begin
                errors++;
                $display("FAIL %s: actual irq,flags=%b expected %b", t, {irq, flags}, e);
            end
        end
    end

    task automatic cyc(input string tag);
        logic fall, rise, w1c, dwr, drd, tset, tdone, am;
        logic [7:0] n;
        fall = m_pv & ~m_s2;
        rise = ~m_pv & m_s2;
        w1c  = bus_wr && bus_addr == 8'h18;
        dwr  = bus_wr && bus_addr == 8'h28;
        drd  = bus_rd && bus_addr == 8'h28;
        am   = (frame_fmt == 4'h2);
        tdone = !is_host && rise && m_st == 2;
        tset = is_host ? (shift_done && !tx_pending) : tdone;
        n = 8'h00;
        n[7] = err_underrun | err_overflow | err_length | (m_f[7] & ~(w1c & bus_wdata[7]));
        n[3] = (!is_host & ssl_det_en & fall) | (m_f[3] & ~(w1c & bus_wdata[3]));
        n[2] = rx_enable & rx_unread & ~drd;
        n[1] = tset | (m_f[1] & ~((w1c & bus_wdata[1]) | dwr));
        n[0] = tx_empty & ~dwr;
        m_irq = |(m_f & irq_en);
        m_f = n;
        if (is_host) m_st = 0;
        else if (m_st == 0) begin
            if (fall) m_st = am ? 1 : 2;
        end else if (m_st == 1) begin
            if (rise) m_st = 0;
            else if (addr_match) m_st = 2;
        end else if (rise) m_st = 0;
        m_pv = m_s2; m_s2 = m_s1; m_s1 = ss_pin;
        exq.push_back({m_irq, m_f});
        tgq.push_back(tag);
        @(posedge clk);
        @(negedge clk);
        #1;
    endtask

    task automatic clr_strobes();
        err_underrun = 0; err_overflow = 0; err_length = 0;
        addr_match = 0; shift_done = 0; bus_wr = 0; bus_rd = 0;
        bus_addr = 8'h00; bus_wdata = 8'h00;
    endtask

    task automatic wflag(input logic [7:0] d);
        bus_wr = 1; bus_addr = 8'h18; bus_wdata = d;
    endtask

    task automatic idle(input int n, input string tag);
        for (int i = 0; i < n; i++) cyc(tag);
    endtask

    initial begin
        #(20 * 150000);
        errors++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        #1;
        checks++;
        if ({irq, flags} !== 9'h000) begin
            errors++;
            $display("FAIL R1 reset: actual %b expected 000000000", {irq, flags});
        end
        rst_n = 1;
        // R2 error pulses, write-0 no effect, w1c
        err_underrun = 1; cyc("R2 underrun"); clr_strobes();
        wflag(8'h00); cyc("R2 write0"); clr_strobes();
        wflag(8'h80); cyc("R2 w1c"); clr_strobes();
        err_length = 1; cyc("R2 length"); clr_strobes();
        // R10 set wins over clear
        err_overflow = 1; wflag(8'h80); cyc("R10 err set wins"); clr_strobes();
        wflag(8'hFF); cyc("R1 R4 clear all"); clr_strobes();
        // R3 client select-low
        is_host = 0; ssl_det_en = 1; idle(2, "R3 settle");
        ss_pin = 0; idle(4, "R3 fall client");
        ss_pin = 1; idle(4, "R7 rise plain");
        wflag(8'h08); cyc("R4 ssl w1c"); clr_strobes();
        wflag(8'h02); cyc("R8 txc w1c"); clr_strobes();
        ssl_det_en = 0; ss_pin = 0; idle(4, "R3 disabled");
        ss_pin = 1; idle(4, "R7 rise");
        wflag(8'h02); cyc("R8 w1c"); clr_strobes();
        // R7 address framing
        ssl_det_en = 1; frame_fmt = 4'h2;
        ss_pin = 0; idle(4, "R7 no match sel");
        ss_pin = 1; idle(4, "R7 no match end");
        ss_pin = 0; idle(4, "R7 sel");
        addr_match = 1; cyc("R7 match"); clr_strobes();
        ss_pin = 1; idle(4, "R7 matched end");
        bus_wr = 1; bus_addr = 8'h28; cyc("R8 data write"); clr_strobes();
        wflag(8'h08); cyc("R4 clear"); clr_strobes();
        // R3 host mode ignores select
        is_host = 1; frame_fmt = 4'h0; idle(2, "R3 host");
        ss_pin = 0; idle(4, "R3 host fall");
        ss_pin = 1; idle(4, "R3 host rise");
        // R6 host transfer done
        tx_pending = 1; shift_done = 1; cyc("R6 pending"); clr_strobes();
        tx_pending = 0; shift_done = 1; cyc("R6 done"); clr_strobes();
        wflag(8'h02); shift_done = 1; cyc("R10 txc set wins"); clr_strobes();
        bus_wr = 1; bus_addr = 8'h28; cyc("R8 data write clear"); clr_strobes();
        // R5 receive complete
        rx_enable = 1; rx_unread = 1; cyc("R5 unread");
        wflag(8'h04); cyc("R5 write no effect"); clr_strobes();
        bus_rd = 1; bus_addr = 8'h28; cyc("R5 data read"); clr_strobes();
        cyc("R5 again");
        rx_enable = 0; cyc("R5 disabled");
        rx_unread = 0; rx_enable = 1; cyc("R5 empty");
        // R9 data empty
        tx_empty = 1; cyc("R9 empty");
        wflag(8'h01); cyc("R9 w1c no effect"); clr_strobes();
        bus_wr = 1; bus_addr = 8'h28; cyc("R9 data write"); clr_strobes();
        cyc("R9 back");
        // R11 interrupt
        irq_en = 8'h01; idle(2, "R11 dre irq");
        irq_en = 8'h80; idle(2, "R11 masked");
        err_length = 1; cyc("R11 err"); clr_strobes();
        idle(2, "R11 err irq");
        wflag(8'h80); cyc("R11 clear"); clr_strobes();
        idle(2, "R11 quiet");
        tx_empty = 0; irq_en = 8'hFF; idle(2, "R11 all");
        idle(2, "tail");
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule